// File: doc/BRIEF.md
# Quadrature and Pulse Input Decoder

This block sits between two incremental position-sensor pins and a position counter. It turns the pin activity into single-cycle count-up and count-down strobes. A mode input chooses how the two pins are read. In quadrature mode they are two phase-shifted square waves. In pulse mode they are separate up and down pulse lines. Both pins are brought into the system clock domain by a synchroniser, and a further registered copy is kept so that changes between samples can be seen.

In quadrature mode the block counts at one, two or four times the line rate. It reports the direction of the most recent count. It also raises a sticky flag whenever both phases change within one sample, which cannot happen on a clean signal. A direction-invert input reverses the counting sense in both modes.

Correct operation needs the quadrature inputs to change no faster than one quarter of the clock rate. Pulse inputs must change no faster than one half of the clock rate.

Top module: `quad_pulse_decoder`

## Requirements
- R1: With `pulse_mode` high, a rising edge on `in_a` gives one up strobe, a rising edge on `in_b` gives one down strobe, and falling edges give nothing.
- R2: With `pulse_mode` low and `invert_dir` low, transitions in which phase A leads phase B (00→10→11→01→00, written {A,B}) count up, and the reverse order counts down.
- R3: With `edge_sel` = 2'b00 (also the setting assumed after reset), quadrature counting happens only when A rises: 00→10 is up and 01→11 is down.
- R4: With `edge_sel` = 2'b01, quadrature counting happens on both edges of A and never on a change of B alone.
- R5: With `edge_sel` = 2'b10 or 2'b11, every legal quadrature transition produces a strobe.
- R6: In quadrature mode, a sample in which A and B both toggle produces no strobe and sets `abnormal`. In pulse mode `abnormal` is never set.
- R7: `abnormal` stays set until `abn_clr` is high for one clock, and it reads 0 on the clock after that.
- R8: A high `invert_dir` swaps up and down strobes in both modes.
- R9: A strobe appears exactly 3 clocks after the input change that causes it and lasts one clock. `cnt_up` and `cnt_dn` are never high together. In pulse mode, simultaneous rising edges on both pins give no strobe.
- R10: `dir_up` is 1 after the last up strobe and 0 after the last down strobe. It changes only together with a strobe.
- R11: After reset, `cnt_up`, `cnt_dn` and `abnormal` are 0 and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | 1: separate up/down pulse pins, 0: quadrature A/B |
| edge_sel | input | 2 | Quadrature evaluation: 00 single, 01 double, 1x quad |
| invert_dir | input | 1 | Reverses the counting sense |
| in_a | input | 1 | Phase A or up pulse pin (asynchronous) |
| in_b | input | 1 | Phase B or down pulse pin (asynchronous) |
| abn_clr | input | 1 | One-clock pulse that clears the abnormal flag |
| cnt_up | output | 1 | One-clock count-up strobe |
| cnt_dn | output | 1 | One-clock count-down strobe |
| dir_up | output | 1 | Direction of the last count (1 = up) |
| abnormal | output | 1 | Sticky illegal-transition flag |

## Verification
A strobe, a direction change or a newly set abnormal flag is due three clocks after the pin change that causes it: two synchroniser stages, then the output register. A flag clear is due one clock after the `abn_clr` pulse. The driver changes the pins half a clock away from the active edge and records the result it expects together with the clock number when that result is due. The monitor compares on that clock and requires both strobes to be low on every other clock. Pin changes are spaced four clocks apart, so each result stands alone.

// File: rtl/quad_pulse_decoder.sv
module quad_pulse_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_mode,
  input  logic [1:0] edge_sel,
  input  logic       invert_dir,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       abn_clr,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       dir_up,
  output logic       abnormal
);

  localparam int CUR = SYNC_STAGES - 1;
  localparam int PRV = SYNC_STAGES;

  logic [SYNC_STAGES:0] pipe_a, pipe_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pipe_a <= '0;
      pipe_b <= '0;
    end else begin
      pipe_a <= {pipe_a[SYNC_STAGES-1:0], in_a};
      pipe_b <= {pipe_b[SYNC_STAGES-1:0], in_b};
    end

  wire ca = pipe_a[CUR];
  wire cb = pipe_b[CUR];
  wire pa = pipe_a[PRV];
  wire pb = pipe_b[PRV];

  wire tog_a   = ca ^ pa;
  wire tog_b   = cb ^ pb;
  wire illegal = tog_a & tog_b;

  wire q_fwd = tog_a ? (ca ^ cb) : ~(ca ^ cb);
  logic q_hit;
  always_comb
    case (edge_sel)
      2'b00:   q_hit = tog_a & ca & ~tog_b;
      2'b01:   q_hit = tog_a & ~tog_b;
      default: q_hit = tog_a ^ tog_b;
    endcase

  wire rise_a = ca & ~pa;
  wire rise_b = cb & ~pb;
  wire p_hit  = rise_a ^ rise_b;

  wire hit   = pulse_mode ? p_hit : q_hit;
  wire go_up = (pulse_mode ? rise_a : q_fwd) ^ invert_dir;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_up   <= 1'b0;
      cnt_dn   <= 1'b0;
      dir_up   <= 1'b1;
      abnormal <= 1'b0;
    end else begin
      cnt_up   <= hit & go_up;
      cnt_dn   <= hit & ~go_up;
      if (hit) dir_up <= go_up;
      abnormal <= (~pulse_mode & illegal) | (abnormal & ~abn_clr);
    end

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_mode,
  input logic [1:0] edge_sel,
  input logic       invert_dir,
  input logic       in_a,
  input logic       in_b,
  input logic       abn_clr,
  input logic       cnt_up,
  input logic       cnt_dn,
  input logic       dir_up,
  input logic       abnormal
);

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));

  assert_dir_after_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_up |-> dir_up);

  assert_dir_after_dn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dn |-> !dir_up);

  assert_dir_moves_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_up) |-> (cnt_up || cnt_dn));

  assert_abn_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(abnormal) && !$past(abn_clr)) |-> abnormal);

  assert_abn_only_quad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abnormal) |-> !$past(pulse_mode));

  assert_illegal_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abnormal) |-> (!cnt_up && !cnt_dn));

endmodule

bind quad_pulse_decoder qpd_checker i_qpd_checker (.*);

// File: tb/test_quad_pulse_decoder.sv
`timescale 1ns/1ps
module test_quad_pulse_decoder;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pulse_mode = 1'b0, invert_dir = 1'b0, in_a = 1'b0, in_b = 1'b0, abn_clr = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic cnt_up, cnt_dn, dir_up, abnormal;

  quad_pulse_decoder i_quad_pulse_decoder (.*);

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    logic  up, dn, dir, abn;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  logic exp_dir = 1'b1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic na, input logic nb, input logic eu, input logic ed,
                      input logic eabn, input string req);
    exp_t e;
    in_a = na;
    in_b = nb;
    if (eu) exp_dir = 1'b1;
    if (ed) exp_dir = 1'b0;
    e.due = cyc + 3; e.up = eu; e.dn = ed; e.dir = exp_dir; e.abn = eabn; e.req = req;
    q.push_back(e);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flag();
    abn_clr = 1'b1;
    @(negedge clk);
    abn_clr = 1'b0;
    chk("R7", "abnormal after clear", abnormal, 0);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "cnt_up", cnt_up, e.up);
        chk(e.req, "cnt_dn", cnt_dn, e.dn);
        chk(e.req, "dir_up", dir_up, e.dir);
        chk(e.req, "abnormal", abnormal, e.abn);
      end else if (cnt_up || cnt_dn) begin
        checks++;
        fails++;
        $display("FAIL R9 unexpected strobe at cycle %0d actual up=%0d dn=%0d expected up=0 dn=0",
                 cyc, cnt_up, cnt_dn);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "cnt_up reset", cnt_up, 0);
    chk("R11", "cnt_dn reset", cnt_dn, 0);
    chk("R11", "dir_up reset", dir_up, 1);
    chk("R11", "abnormal reset", abnormal, 0);

    // R3 single edge, forward then reverse
    step(1,0, 1,0,0,"R3"); step(1,1, 0,0,0,"R3"); step(0,1, 0,0,0,"R3"); step(0,0, 0,0,0,"R3");
    step(0,1, 0,0,0,"R3"); step(1,1, 0,1,0,"R2"); step(1,0, 0,0,0,"R3"); step(0,0, 0,0,0,"R10");

    // R4 double edge
    edge_sel = 2'b01;
    step(1,0, 1,0,0,"R4"); step(1,1, 0,0,0,"R4"); step(0,1, 1,0,0,"R4"); step(0,0, 0,0,0,"R4");
    step(0,1, 0,0,0,"R4"); step(1,1, 0,1,0,"R4"); step(1,0, 0,0,0,"R4"); step(0,0, 0,1,0,"R4");

    // R5 quad edge, R2 direction
    edge_sel = 2'b10;
    step(1,0, 1,0,0,"R5"); step(1,1, 1,0,0,"R5"); step(0,1, 1,0,0,"R5"); step(0,0, 1,0,0,"R5");
    step(0,1, 0,1,0,"R2"); step(1,1, 0,1,0,"R2"); step(1,0, 0,1,0,"R2"); step(0,0, 0,1,0,"R2");

    // R6 illegal transitions, R7 sticky until cleared
    step(1,1, 0,0,1,"R6"); step(0,1, 1,0,1,"R7");
    clear_flag();
    step(0,0, 1,0,0,"R5");
    edge_sel = 2'b11;
    step(1,0, 1,0,0,"R5"); step(0,1, 0,0,1,"R6");
    clear_flag();
    step(0,0, 1,0,0,"R5");

    // R8 inverted quadrature
    invert_dir = 1'b1;
    step(1,0, 0,1,0,"R8"); step(0,0, 1,0,0,"R8");
    invert_dir = 1'b0;

    // R1 pulse mode
    pulse_mode = 1'b1;
    step(1,0, 1,0,0,"R1"); step(0,0, 0,0,0,"R1"); step(0,1, 0,1,0,"R1"); step(0,0, 0,0,0,"R10");
    step(1,1, 0,0,0,"R9"); step(0,0, 0,0,0,"R9");
    step(1,0, 1,0,0,"R1"); step(0,1, 0,1,0,"R6"); step(0,0, 0,0,0,"R6");
    invert_dir = 1'b1;
    step(1,0, 0,1,0,"R8"); step(0,0, 0,0,0,"R8"); step(0,1, 1,0,0,"R8"); step(0,0, 0,0,0,"R8");
    invert_dir = 1'b0;

    repeat (4) @(negedge clk);
    if (q.size() != 0) chk("R9", "pending expectations", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule